// File: doc/BRIEF.md
# Prioritized External Interrupt Extender

This block combines four external interrupt pins into one request line for the single external-interrupt entry of an 8051-class core. Each pin is synchronized to the core clock, and its edges are detected in the direction that software selects. An enabled pin that sees its chosen edge sets a sticky pending flag. The flag stays set until software writes a one to it, so an edge that arrives while a handler runs is never lost.

Each pin has a 3-bit priority, and a larger value means a more urgent pin. A pending pin is eligible only if it is enabled and its priority is strictly above a global threshold. The block raises its request while any pin is eligible. A result register names the most urgent eligible pin, so the shared handler can find its cause without polling every flag.

The CPU pulses an acknowledge when it enters the handler and a return pulse when it leaves. Between the two pulses the request is held low, so the extended sources never nest. A more urgent pin that fires during a handler is served after the return.

Top module: `ext_irq_merger`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_req` is low. Edge select 0 means falling edge.
- R2: The direction of each pin's edge is set by bit i of the edge-select register at address 0x1: 1 = rising, 0 = falling. The opposite edge has no effect. An edge sets pending bit i only when bit i of the enable register at address 0x0 is 1.
- R3: The pending register at address 0x3 (bits 3:0) is sticky. Writing 1 to a bit clears it, and writing 0 has no effect. If an edge and a clear for the same bit fall in the same cycle, the bit stays set.
- R4: A pin is eligible when it is pending, enabled, and its priority is strictly greater than the threshold at address 0x2 (bits 2:0). `irq_req` is a registered output that is high while any pin is eligible and no handler is in service.
- R5: The result register at address 0x4 gives the most urgent eligible pin: bit 7 = valid, bits 1:0 = pin index. Among pins of equal priority, the lowest index wins.
- R6: `irq_ack` puts the block in service, and `irq_req` is low from the next cycle until `irq_ret` is pulsed. Edges that arrive during service are still latched, and the most urgent pending pin is requested after the return.
- R7: Pin priorities live at address 0x8 (pin 0 in bits 2:0, pin 1 in bits 6:4) and at address 0x9 (pin 2 in bits 2:0, pin 3 in bits 6:4). `rd_data` returns the register at `rd_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 4 | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq_ack | input | 1 | Handler entry pulse from the CPU |
| irq_ret | input | 1 | Handler exit pulse from the CPU |
| irq_req | output | 1 | Combined request to the CPU's external-interrupt channel |

## Verification
A table of configurations fires groups of pins and checks the pending flags, the request and the result register. The patterns are built to separate distinct behaviours: rising from falling edges, enabled from disabled pins, strict from non-strict threshold comparison, and a priority win from a tie settled by pin index. Directed sequences then check the reset state, that the opposite edge is ignored, and that writing zero leaves flags alone. They also place a set and a clear in the same cycle, and fire a more urgent pin inside a handler to confirm it is held back and then requested after the return.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int A_ENABLE = 0;
  localparam int A_EDGE   = 1;
  localparam int A_THRESH = 2;
  localparam int A_PEND   = 3;
  localparam int A_RESULT = 4;
  localparam int A_PRIO   = 8;
  localparam int PRIO_LANE = 4;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] rise_sel,
  output logic [NPIN-1:0] edge_hit
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic meta_q, sync_q, last_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= pin_in[i];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end
    assign edge_hit[i] = rise_sel[i] ? (sync_q & ~last_q) : (~sync_q & last_q);
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NPIN  = 4,
  parameter int PW    = 3,
  parameter int IDX_W = 2
) (
  input  logic [NPIN-1:0]         pend,
  input  logic [NPIN-1:0]         en,
  input  logic [NPIN-1:0][PW-1:0] prio,
  input  logic [PW-1:0]           thr,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);
  logic [PW-1:0] best;
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (pend[i] && en[i] && (prio[i] > thr)) begin
        if (!any || (prio[i] > best)) begin
          any  = 1'b1;
          idx  = IDX_W'(i);
          best = prio[i];
        end
      end
    end
  end
endmodule

// File: rtl/ext_irq_merger.sv
module ext_irq_merger
  import irq_merge_pkg::*;
#(
  parameter int NPIN   = 4,
  parameter int PW     = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req
);
  localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;

  logic [NPIN-1:0]         en_q, sel_q, pend_q, edge_hit, clr_mask;
  logic [NPIN-1:0][PW-1:0] prio_q;
  logic [PW-1:0]           thr_q;
  logic                    in_svc_q, in_svc_nxt;
  logic                    win_valid_q, pick_any;
  logic [IDX_W-1:0]        win_idx_q, pick_idx;

  irq_edge_det #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rise_sel(sel_q), .edge_hit(edge_hit)
  );

  irq_pick #(.NPIN(NPIN), .PW(PW), .IDX_W(IDX_W)) u_pick (
    .pend(pend_q), .en(en_q), .prio(prio_q), .thr(thr_q),
    .any(pick_any), .idx(pick_idx)
  );

  assign clr_mask = (wr_en && wr_addr == ADDR_W'(A_PEND)) ? wr_data[NPIN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      sel_q  <= '0;
      thr_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_ENABLE)) en_q  <= wr_data[NPIN-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_EDGE))   sel_q <= wr_data[NPIN-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_THRESH)) thr_q <= wr_data[PW-1:0];
      pend_q <= (pend_q & ~clr_mask) | (edge_hit & en_q);
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_prio
    localparam int RADDR = A_PRIO + i / 2;
    localparam int LSB   = PRIO_LANE * (i % 2);
    always_ff @(posedge clk) begin
      if (rst) prio_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(RADDR)) prio_q[i] <= wr_data[LSB +: PW];
    end
  end

  always_comb begin
    in_svc_nxt = in_svc_q;
    if (irq_ack)      in_svc_nxt = 1'b1;
    else if (irq_ret) in_svc_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_svc_q    <= 1'b0;
      irq_req     <= 1'b0;
      win_valid_q <= 1'b0;
      win_idx_q   <= '0;
    end else begin
      in_svc_q    <= in_svc_nxt;
      irq_req     <= pick_any & ~in_svc_nxt;
      win_valid_q <= pick_any;
      win_idx_q   <= pick_idx;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(A_ENABLE)) rd_mux[NPIN-1:0] = en_q;
    if (rd_addr == ADDR_W'(A_EDGE))   rd_mux[NPIN-1:0] = sel_q;
    if (rd_addr == ADDR_W'(A_THRESH)) rd_mux[PW-1:0]   = thr_q;
    if (rd_addr == ADDR_W'(A_PEND))   rd_mux[NPIN-1:0] = pend_q;
    if (rd_addr == ADDR_W'(A_RESULT)) begin
      rd_mux[DATA_W-1]  = win_valid_q;
      rd_mux[IDX_W-1:0] = win_idx_q;
    end
    for (int i = 0; i < NPIN; i++) begin
      if (rd_addr == ADDR_W'(A_PRIO + i / 2))
        rd_mux[PRIO_LANE * (i % 2) +: PW] = prio_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/ext_irq_merger_chk.sv
module ext_irq_merger_chk
  import irq_merge_pkg::*;
#(
  parameter int NPIN   = 4,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_req,
  input logic              irq_ack,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NPIN-1:0]   pend_q,
  input logic [NPIN-1:0]   en_q,
  input logic              in_svc_q,
  input logic              win_valid_q,
  input logic [IDX_W-1:0]  win_idx_q
);
  logic [NPIN-1:0] elig_d;
  always_ff @(posedge clk) begin
    if (rst) elig_d <= '0;
    else     elig_d <= pend_q & en_q;
  end

  p_en_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~$past(pend_q) & ~$past(en_q)) == '0);

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> $past(wr_en && wr_addr == ADDR_W'(A_PEND)));

  p_req_src_r4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(|(pend_q & en_q)));

  p_win_pending_r5: assert property (@(posedge clk) disable iff (rst)
    win_valid_q |-> elig_d[win_idx_q]);

  p_ack_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_req);

  p_svc_gate_r6: assert property (@(posedge clk) disable iff (rst)
    in_svc_q |-> !irq_req);
endmodule

bind ext_irq_merger ext_irq_merger_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack),
  .wr_en(wr_en), .wr_addr(wr_addr), .pend_q(pend_q), .en_q(en_q),
  .in_svc_q(in_svc_q), .win_valid_q(win_valid_q), .win_idx_q(win_idx_q)
);

// File: tb/ext_irq_merger_bench.sv
module ext_irq_merger_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pin_in = 4'h0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h0;
  logic [3:0] rd_addr = 4'h0;
  logic [7:0] rd_data;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic       irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_merger u_ext_irq_merger (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req)
  );

  // {en[4], rise[4], prio p3..p0 [12], thr[3], fire[4], exp_pend[4], exp_req[1], exp_win {valid,idx}[3]}
  localparam logic [34:0] VEC [6] = '{
    {4'hF, 4'hF, 12'b100_011_010_001, 3'd0, 4'hF, 4'hF, 1'b1, 3'b111},
    {4'hF, 4'h0, 12'b101_101_101_101, 3'd2, 4'h6, 4'h6, 1'b1, 3'b101},
    {4'h3, 4'hF, 12'b111_111_111_111, 3'd0, 4'hF, 4'h3, 1'b1, 3'b100},
    {4'hF, 4'hA, 12'b010_110_011_011, 3'd3, 4'hB, 4'hB, 1'b0, 3'b000},
    {4'hF, 4'h5, 12'b111_110_111_110, 3'd5, 4'hF, 4'hF, 1'b1, 3'b101},
    {4'hF, 4'hF, 12'b111_111_111_111, 3'd7, 4'hF, 4'hF, 1'b0, 3'b000}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse_ack(input bit ret);
    @(negedge clk);
    if (ret) irq_ret = 1'b1; else irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0; irq_ret = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    cycles(3);
    rst = 1'b0;
    cycles(1);

    // R1: reset state
    check(irq_req == 1'b0, "R1 irq_req", irq_req, 0);
    for (int a = 0; a < 10; a++) begin
      reg_rd(4'(a), r);
      check(r == 8'h00, "R1 register after reset", r, 0);
    end

    // Table walk: R2 R4 R5 R7
    for (int v = 0; v < 6; v++) begin
      logic [3:0] en, rise, fire, ep;
      logic [11:0] pr;
      logic [2:0] thr, ew;
      logic er;
      {en, rise, pr, thr, fire, ep, er, ew} = VEC[v];
      reg_wr(4'h0, {4'h0, en});
      reg_wr(4'h1, {4'h0, rise});
      reg_wr(4'h2, {5'h0, thr});
      reg_wr(4'h8, {1'b0, pr[5:3], 1'b0, pr[2:0]});
      reg_wr(4'h9, {1'b0, pr[11:9], 1'b0, pr[8:6]});
      reg_rd(4'h9, r);
      check(r == {1'b0, pr[11:9], 1'b0, pr[8:6]}, "R7 priority readback", r, {1'b0, pr[11:9], 1'b0, pr[8:6]});
      pin_in = ~rise;
      cycles(5);
      reg_wr(4'h3, 8'h0F);
      cycles(2);
      pin_in = pin_in ^ fire;
      cycles(6);
      check(irq_req == er, "R4 request level", irq_req, er);
      reg_rd(4'h3, r);
      check(r == {4'h0, ep}, "R2 pending flags", r, ep);
      reg_rd(4'h4, r);
      check(r == {ew[2], 5'h0, ew[1:0]}, "R5 result register", r, {ew[2], 5'h0, ew[1:0]});
    end

    // R2: opposite edge ignored
    reg_wr(4'h0, 8'h0F);
    reg_wr(4'h1, 8'h0F);
    reg_wr(4'h2, 8'h00);
    pin_in = 4'h0;
    cycles(5);
    reg_wr(4'h3, 8'h0F);
    cycles(2);
    reg_rd(4'h3, r);
    check(r == 8'h00, "R3 clear all", r, 0);
    pin_in = 4'h1;
    cycles(5);
    reg_wr(4'h3, 8'h01);
    cycles(2);
    pin_in = 4'h0;
    cycles(6);
    reg_rd(4'h3, r);
    check(r == 8'h00, "R2 falling edge ignored when rising selected", r, 0);

    // R3: writing zero has no effect
    pin_in = 4'h4;
    cycles(5);
    reg_wr(4'h3, 8'h00);
    reg_rd(4'h3, r);
    check(r == 8'h04, "R3 write zero keeps flag", r, 4);
    reg_wr(4'h3, 8'h04);
    reg_rd(4'h3, r);
    check(r == 8'h00, "R3 write one clears flag", r, 0);

    // R3: set and clear in the same cycle, set wins
    @(negedge clk);
    pin_in = 4'h6;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'h3; wr_data = 8'h02;
    @(negedge clk);
    wr_en = 1'b0;
    reg_rd(4'h3, r);
    check(r == 8'h02, "R3 set wins over same-cycle clear", r, 2);
    reg_wr(4'h3, 8'h0F);
    pin_in = 4'h0;
    cycles(5);
    reg_wr(4'h3, 8'h0F);

    // R6: no nesting, edge kept during service
    reg_wr(4'h8, 8'h62);
    cycles(2);
    pin_in = 4'h1;
    cycles(6);
    check(irq_req == 1'b1, "R6 request before ack", irq_req, 1);
    pulse_ack(1'b0);
    check(irq_req == 1'b0, "R6 request dropped after ack", irq_req, 0);
    pin_in = 4'h3;
    cycles(6);
    check(irq_req == 1'b0, "R6 higher pin held during service", irq_req, 0);
    reg_rd(4'h3, r);
    check(r == 8'h03, "R6 edge latched during service", r, 3);
    reg_wr(4'h3, 8'h01);
    pulse_ack(1'b1);
    check(irq_req == 1'b1, "R6 request after return", irq_req, 1);
    reg_rd(4'h4, r);
    check(r == 8'h81, "R5 result after return", r, 8'h81);

    // R1: reset clears state again
    @(negedge clk);
    rst = 1'b1;
    cycles(2);
    rst = 1'b0;
    cycles(1);
    check(irq_req == 1'b0, "R1 irq_req after second reset", irq_req, 0);
    reg_rd(4'h3, r);
    check(r == 8'h00, "R1 pending after second reset", r, 0);

    finish_run();
  end
endmodule